// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

At every instruction boundary a processor core has to decide which asynchronous event, if any, it services before the next instruction starts. This block makes that decision. It holds pending system-management, init and non-maskable requests. It also holds the debug-trap word and the one-instruction inhibit shadow left by STI or by a stack-segment load. When the core strobes a boundary, the block takes the single highest-priority eligible event.

The result appears one cycle after the boundary strobe. It is a one-hot take vector with an 8-bit vector number where one applies. A maskable interrupt also produces an acknowledge to whichever interrupt controller supplies it. The core uses `async_pend` to skip evaluation while nothing can be taken.

Top module: `evt_boundary_arb`

## Requirements
- R1: `take` is registered and at most one bit is set. A bit is set only in the cycle after a cycle with `bnd` high; after reset and in other cycles `take`, `take_vec` and both acknowledges are zero. Bit positions: 0 task-switch trap, 1 SMI, 2 INIT, 3 debug trap, 4 NMI, 5 maskable interrupt, 6 hold acknowledge.
- R2: Among eligible events the order is: task-switch trap, SMI, INIT, debug trap, NMI, maskable interrupt, hold acknowledge. Events that are not taken stay pending.
- R3: A task-switch trap (`ts_trap` high at the boundary) is taken with vector 1.
- R4: An `smi_in` pulse is latched. While `smi_mask` is high the request stays pending without being taken. Acceptance clears it.
- R5: An `init_in` pulse is latched only if `init_mask` is low at arrival. Acceptance clears it.
- R6: An accepted NMI carries vector 2 and blocks further NMIs until an `nmi_unmask` pulse. Maskable interrupts are still taken while NMIs are blocked.
- R7: A maskable interrupt is eligible only with `if_flag` high. A pending `loc_irq` wins, with `loc_ack` and `loc_vec`. Otherwise `leg_ack` is asserted and `leg_vec` is used.
- R8: The debug-trap word is `dbg_stat` ORed with the stored word. It fires (vector 1) when any of bits 15:12 is set; a boundary without firing and without shadow clears it. `tf_flag` high at a boundary sets bit 14, so the trap fires at the next boundary.
- R9: An `inh_req` pulse during an instruction records `inh_bits` (bit 0 interrupt, bit 1 debug, bit 2 stack load) and a limit of the instruction count plus one. Only the boundary that ends that instruction is shadowed. Bit 0 holds back NMI and maskable interrupts, and bit 1 holds back debug traps. A query needs every requested bit stored.
- R10: While a shadow recorded with bit 2 is live, a further `inh_req` is ignored; without bit 2 a new request re-arms the shadow.
- R11: Hold acknowledge is taken only when `hold_req` is high and no other event is taken at that boundary.
- R12: `async_pend` falls only at a boundary that leaves no unmasked pending event, a zero debug-trap word and `hold_req` low. Between boundaries it rises when any of these appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd | input | 1 | Instruction boundary strobe |
| if_flag | input | 1 | Interrupt enable flag |
| tf_flag | input | 1 | Single-step flag, sampled at the boundary |
| ts_trap | input | 1 | Task-switch trap, sampled at the boundary |
| dbg_stat | input | 16 | Debug status from the finished instruction |
| inh_req | input | 1 | Inhibit shadow request pulse |
| inh_bits | input | 3 | Inhibit kinds: 0 interrupt, 1 debug, 2 stack load |
| smi_in | input | 1 | SMI request pulse |
| smi_mask | input | 1 | Holds off SMI acceptance |
| init_in | input | 1 | INIT request pulse |
| init_mask | input | 1 | Blocks INIT latching |
| nmi_in | input | 1 | NMI request pulse |
| nmi_unmask | input | 1 | Re-enables NMI delivery |
| leg_irq | input | 1 | Legacy controller interrupt level |
| leg_vec | input | 8 | Legacy controller vector |
| loc_irq | input | 1 | Local controller interrupt level |
| loc_vec | input | 8 | Local controller vector |
| hold_req | input | 1 | DMA hold request |
| take | output | 7 | One-hot taken event |
| take_vec | output | 8 | Vector of the taken event |
| leg_ack | output | 1 | Acknowledge to legacy controller |
| loc_ack | output | 1 | Acknowledge to local controller |
| async_pend | output | 1 | Something may be taken at a boundary |

## Verification
The bench builds the block with `CNT_W` set to 3. The instruction counter therefore wraps several times over the run. Shadow records, chained STI requests and stack-load lockouts are then exercised across the wrap point, where a magnitude compare instead of an equality compare would misbehave. The remaining parameters keep their defaults, so the bit positions in the requirements apply as written.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
    localparam int VEC_W       = 8;
    localparam int DBG_W       = 16;
    localparam int DBG_FIRE_LO = 12;
    localparam int DBG_FIRE_HI = 15;
    localparam int DBG_STEP    = 14;

    localparam int INH_W    = 3;
    localparam int INH_INTR = 0;
    localparam int INH_DBG  = 1;
    localparam int INH_SS   = 2;

    // Event slots, lowest index wins.
    localparam int N_EV    = 7;
    localparam int EV_TS   = 0;
    localparam int EV_SMI  = 1;
    localparam int EV_INIT = 2;
    localparam int EV_DBG  = 3;
    localparam int EV_NMI  = 4;
    localparam int EV_INTR = 5;
    localparam int EV_HOLD = 6;

    localparam logic [VEC_W-1:0] VEC_DB  = VEC_W'(1);
    localparam logic [VEC_W-1:0] VEC_NMI = VEC_W'(2);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LOC  = 2'd1,
        SRC_LEG  = 2'd2
    } irq_src_e;

    typedef struct packed {
        logic [N_EV-1:0]  take;
        logic [VEC_W-1:0] vec;
        irq_src_e         src;
    } pick_t;

    function automatic logic inh_has(input logic [INH_W-1:0] stored,
                                     input logic [INH_W-1:0] want);
        return (stored & want) == want;
    endfunction

    function automatic logic trap_fires(input logic [DBG_W-1:0] word);
        return |word[DBG_FIRE_HI:DBG_FIRE_LO];
    endfunction
endpackage

// File: rtl/eva_inhibit.sv
module eva_inhibit
    import evt_arb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bnd,
    input  logic             req,
    input  logic [INH_W-1:0] req_bits,
    output logic             intr_inh,
    output logic             dbg_inh
);
    localparam logic [INH_W-1:0] Q_INTR = INH_W'(1) << INH_INTR;
    localparam logic [INH_W-1:0] Q_DBG  = INH_W'(1) << INH_DBG;

    logic [CNT_W-1:0] ic_q, lim_q, ic_nx;
    logic             valid_q;
    logic [INH_W-1:0] mask_q;
    logic             accept, closing;

    assign ic_nx   = ic_q + CNT_W'(1);
    // The boundary ending instruction lim-1 is the shadowed one.
    assign closing = valid_q && (ic_nx == lim_q);
    assign accept  = req && !(valid_q && mask_q[INH_SS]);

    assign intr_inh = closing && inh_has(mask_q, Q_INTR);
    assign dbg_inh  = closing && inh_has(mask_q, Q_DBG);

    always_ff @(posedge clk) begin
        if (rst) begin
            ic_q    <= '0;
            lim_q   <= '0;
            valid_q <= 1'b0;
            mask_q  <= '0;
        end else begin
            if (bnd) ic_q <= ic_nx;
            if (accept) begin
                valid_q <= 1'b1;
                mask_q  <= req_bits;
                lim_q   <= bnd ? ic_nx + CNT_W'(1) : ic_nx;
            end else if (bnd && valid_q && (ic_q == lim_q)) begin
                valid_q <= 1'b0;
            end
        end
    end

    // R10: a live stack-load shadow keeps its record against new requests
    a_r10_ss_locks: assert property (@(posedge clk) disable iff (rst)
        (valid_q && mask_q[INH_SS] && req && !bnd) |=> ($stable(lim_q) && $stable(mask_q)));
endmodule

// File: rtl/eva_pending.sv
module eva_pending (
    input  logic clk,
    input  logic rst,
    input  logic smi_in,
    input  logic init_in,
    input  logic init_mask,
    input  logic nmi_in,
    input  logic nmi_unmask,
    input  logic tk_smi,
    input  logic tk_init,
    input  logic tk_nmi,
    output logic smi_p,
    output logic init_p,
    output logic nmi_p,
    output logic nmi_blk,
    output logic smi_nx,
    output logic init_nx,
    output logic nmi_nx,
    output logic blk_nx
);
    assign smi_nx  = smi_in | (smi_p & ~tk_smi);
    assign init_nx = (init_in & ~init_mask) | (init_p & ~tk_init);
    assign nmi_nx  = nmi_in | (nmi_p & ~tk_nmi);
    assign blk_nx  = tk_nmi | (nmi_blk & ~nmi_unmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_p   <= 1'b0;
            init_p  <= 1'b0;
            nmi_p   <= 1'b0;
            nmi_blk <= 1'b0;
        end else begin
            smi_p   <= smi_nx;
            init_p  <= init_nx;
            nmi_p   <= nmi_nx;
            nmi_blk <= blk_nx;
        end
    end

    // R5: a masked INIT arrival leaves no pending request behind
    a_r5_init_masked: assert property (@(posedge clk) disable iff (rst)
        (init_in && init_mask && !init_p) |=> !init_p);
endmodule

// File: rtl/eva_debug.sv
module eva_debug
    import evt_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bnd,
    input  logic             tf,
    input  logic [DBG_W-1:0] stat,
    input  logic             inh,
    input  logic             delivered,
    output logic             fire_ok,
    output logic [DBG_W-1:0] trap_q,
    output logic [DBG_W-1:0] trap_nx
);
    localparam logic [DBG_W-1:0] STEP_MASK = DBG_W'(1) << DBG_STEP;

    logic [DBG_W-1:0] word;
    logic             fire, keep;

    assign word    = trap_q | stat;
    assign fire    = trap_fires(word);
    assign fire_ok = fire && !inh;
    // Kept when shadowed, or when firing but beaten by a higher event.
    assign keep    = !delivered && (inh || fire);
    assign trap_nx = bnd ? ((keep ? word : '0) | (tf ? STEP_MASK : '0)) : trap_q;

    always_ff @(posedge clk) begin
        if (rst) trap_q <= '0;
        else     trap_q <= trap_nx;
    end
endmodule

// File: rtl/eva_select.sv
module eva_select
    import evt_arb_pkg::*;
(
    input  logic             ts_trap,
    input  logic             smi_ok,
    input  logic             init_ok,
    input  logic             dbg_ok,
    input  logic             nmi_ok,
    input  logic             irq_ok,
    input  logic             intr_inh,
    input  logic             hold_req,
    input  logic             loc_irq,
    input  logic [VEC_W-1:0] loc_vec,
    input  logic [VEC_W-1:0] leg_vec,
    output pick_t            pick
);
    logic [N_EV-1:0] req;
    logic [N_EV-1:0] grant;

    always_comb begin
        req          = '0;
        req[EV_TS]   = ts_trap;
        req[EV_SMI]  = smi_ok;
        req[EV_INIT] = init_ok;
        req[EV_DBG]  = dbg_ok;
        req[EV_NMI]  = nmi_ok && !intr_inh;
        req[EV_INTR] = irq_ok && !intr_inh;
        req[EV_HOLD] = hold_req;
    end

    // Fixed-priority first-set scan over the slots.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < N_EV; k++) begin
            if (req[k] && !found) begin
                grant[k] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        pick.take = grant;
        pick.vec  = '0;
        pick.src  = SRC_NONE;
        if (grant[EV_TS] || grant[EV_DBG]) begin
            pick.vec = VEC_DB;
        end else if (grant[EV_NMI]) begin
            pick.vec = VEC_NMI;
        end else if (grant[EV_INTR]) begin
            pick.src = loc_irq ? SRC_LOC : SRC_LEG;
            pick.vec = loc_irq ? loc_vec : leg_vec;
        end
    end
endmodule

// File: rtl/evt_boundary_arb.sv
module evt_boundary_arb
    import evt_arb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bnd,
    input  logic             if_flag,
    input  logic             tf_flag,
    input  logic             ts_trap,
    input  logic [DBG_W-1:0] dbg_stat,
    input  logic             inh_req,
    input  logic [INH_W-1:0] inh_bits,
    input  logic             smi_in,
    input  logic             smi_mask,
    input  logic             init_in,
    input  logic             init_mask,
    input  logic             nmi_in,
    input  logic             nmi_unmask,
    input  logic             leg_irq,
    input  logic [VEC_W-1:0] leg_vec,
    input  logic             loc_irq,
    input  logic [VEC_W-1:0] loc_vec,
    input  logic             hold_req,
    output logic [N_EV-1:0]  take,
    output logic [VEC_W-1:0] take_vec,
    output logic             leg_ack,
    output logic             loc_ack,
    output logic             async_pend
);
    logic             intr_inh, dbg_inh;
    logic             smi_p, init_p, nmi_p, nmi_blk;
    logic             smi_nx, init_nx, nmi_nx, blk_nx;
    logic             fire_ok;
    logic [DBG_W-1:0] trap_q, trap_nx;
    logic             irq_ok;
    pick_t            pick;
    logic [N_EV-1:0]  tk;
    logic             sum_now, sum_nx;

    assign irq_ok = if_flag && (loc_irq || leg_irq);
    assign tk     = bnd ? pick.take : '0;

    eva_inhibit #(.CNT_W(CNT_W)) u_inh (
        .clk(clk), .rst(rst), .bnd(bnd), .req(inh_req), .req_bits(inh_bits),
        .intr_inh(intr_inh), .dbg_inh(dbg_inh)
    );

    eva_pending u_pend (
        .clk(clk), .rst(rst), .smi_in(smi_in), .init_in(init_in),
        .init_mask(init_mask), .nmi_in(nmi_in), .nmi_unmask(nmi_unmask),
        .tk_smi(tk[EV_SMI]), .tk_init(tk[EV_INIT]), .tk_nmi(tk[EV_NMI]),
        .smi_p(smi_p), .init_p(init_p), .nmi_p(nmi_p), .nmi_blk(nmi_blk),
        .smi_nx(smi_nx), .init_nx(init_nx), .nmi_nx(nmi_nx), .blk_nx(blk_nx)
    );

    eva_debug u_dbg (
        .clk(clk), .rst(rst), .bnd(bnd), .tf(tf_flag), .stat(dbg_stat),
        .inh(dbg_inh), .delivered(tk[EV_DBG] || tk[EV_TS]),
        .fire_ok(fire_ok), .trap_q(trap_q), .trap_nx(trap_nx)
    );

    eva_select u_sel (
        .ts_trap(ts_trap), .smi_ok(smi_p && !smi_mask),
        .init_ok(init_p && !init_mask), .dbg_ok(fire_ok),
        .nmi_ok(nmi_p && !nmi_blk), .irq_ok(irq_ok), .intr_inh(intr_inh),
        .hold_req(hold_req), .loc_irq(loc_irq), .loc_vec(loc_vec),
        .leg_vec(leg_vec), .pick(pick)
    );

    assign sum_now = (smi_p && !smi_mask) || (init_p && !init_mask) ||
                     (nmi_p && !nmi_blk) || irq_ok || (|trap_q) || hold_req;
    assign sum_nx  = (smi_nx && !smi_mask) || (init_nx && !init_mask) ||
                     (nmi_nx && !blk_nx) || irq_ok || (|trap_nx) || hold_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            take       <= '0;
            take_vec   <= '0;
            leg_ack    <= 1'b0;
            loc_ack    <= 1'b0;
            async_pend <= 1'b0;
        end else begin
            take       <= tk;
            take_vec   <= bnd ? pick.vec : '0;
            loc_ack    <= bnd && (pick.src == SRC_LOC);
            leg_ack    <= bnd && (pick.src == SRC_LEG);
            async_pend <= bnd ? sum_nx : (async_pend || sum_now);
        end
    end

    // R1: one event at most, and only right after a boundary
    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));
    a_r1_after_bnd: assert property (@(posedge clk) disable iff (rst)
        (|take) |-> $past(bnd));
    // R6: an accepted NMI cannot be followed at once by another
    a_r6_nmi_gap: assert property (@(posedge clk) disable iff (rst)
        take[EV_NMI] |=> !take[EV_NMI]);
    // R7: acknowledges go to exactly one controller, with an interrupt take
    a_r7_ack_pair: assert property (@(posedge clk) disable iff (rst)
        (loc_ack || leg_ack) |-> (take[EV_INTR] && !(loc_ack && leg_ack)));
    // R11: a hold acknowledge needs a hold request at the boundary
    a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
        take[EV_HOLD] |-> $past(hold_req));
    // R12: an idle summary implies an empty debug-trap word
    a_r12_idle: assert property (@(posedge clk) disable iff (rst)
        !async_pend |-> (trap_q == '0));
endmodule

// File: tb/evt_boundary_arb_tb.sv
module evt_boundary_arb_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bnd = 1'b0;
    logic        if_flag = 1'b0, tf_flag = 1'b0, ts_trap = 1'b0;
    logic [15:0] dbg_stat = '0;
    logic        inh_req = 1'b0;
    logic [2:0]  inh_bits = '0;
    logic        smi_in = 1'b0, smi_mask = 1'b0, init_in = 1'b0, init_mask = 1'b0;
    logic        nmi_in = 1'b0, nmi_unmask = 1'b0;
    logic        leg_irq = 1'b0, loc_irq = 1'b0, hold_req = 1'b0;
    logic [7:0]  leg_vec = '0, loc_vec = '0;
    logic [6:0]  take;
    logic [7:0]  take_vec;
    logic        leg_ack, loc_ack, async_pend;

    localparam logic [6:0] T_NONE = 7'd0,  T_TS  = 7'd1,  T_SMI  = 7'd2, T_INIT = 7'd4;
    localparam logic [6:0] T_DBG  = 7'd8,  T_NMI = 7'd16, T_INTR = 7'd32, T_HOLD = 7'd64;

    typedef struct {
        logic [6:0] t;
        logic [7:0] v;
        logic       lo;
        logic       le;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   vectors = 0;
    int   fails = 0;
    logic bnd_seen = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    evt_boundary_arb #(.CNT_W(3)) u_dut (
        .clk(clk), .rst(rst), .bnd(bnd), .if_flag(if_flag), .tf_flag(tf_flag),
        .ts_trap(ts_trap), .dbg_stat(dbg_stat), .inh_req(inh_req), .inh_bits(inh_bits),
        .smi_in(smi_in), .smi_mask(smi_mask), .init_in(init_in), .init_mask(init_mask),
        .nmi_in(nmi_in), .nmi_unmask(nmi_unmask), .leg_irq(leg_irq), .leg_vec(leg_vec),
        .loc_irq(loc_irq), .loc_vec(loc_vec), .hold_req(hold_req),
        .take(take), .take_vec(take_vec), .leg_ack(leg_ack), .loc_ack(loc_ack),
        .async_pend(async_pend)
    );

    always @(posedge clk) bnd_seen <= bnd;

    // Monitor: pops one expectation per boundary, checks idle cycles too.
    always @(negedge clk) begin
        if (bnd_seen) begin
            vectors++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected boundary result: take=%b expected none queued", take);
            end else begin
                cur = q.pop_front();
                if (take !== cur.t || take_vec !== cur.v || loc_ack !== cur.lo || leg_ack !== cur.le) begin
                    fails++;
                    $display("FAIL %s: take=%b vec=%h loc=%b leg=%b expected take=%b vec=%h loc=%b leg=%b",
                             cur.tag, take, take_vec, loc_ack, leg_ack, cur.t, cur.v, cur.lo, cur.le);
                end
            end
        end else if (!rst && (take !== T_NONE || loc_ack !== 1'b0 || leg_ack !== 1'b0)) begin
            vectors++;
            fails++;
            $display("FAIL R1 output outside boundary: take=%b expected %b", take, T_NONE);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic boundary(input logic [15:0] ds, input logic [6:0] t, input logic [7:0] v,
                            input logic lo, input logic le, input string tag);
        exp_t e;
        e.t = t; e.v = v; e.lo = lo; e.le = le; e.tag = tag;
        q.push_back(e);
        dbg_stat = ds;
        bnd = 1'b1;
        tick();
        bnd = 1'b0;
        dbg_stat = '0;
    endtask

    task automatic check_pend(input logic exp, input string tag);
        vectors++;
        if (async_pend !== exp) begin
            fails++;
            $display("FAIL %s: async_pend=%b expected %b", tag, async_pend, exp);
        end
    endtask

    task automatic pulse_nmi();   nmi_in = 1'b1; tick(); nmi_in = 1'b0; endtask
    task automatic pulse_unmask(); nmi_unmask = 1'b1; tick(); nmi_unmask = 1'b0; endtask
    task automatic pulse_smi();   smi_in = 1'b1; tick(); smi_in = 1'b0; endtask
    task automatic pulse_init();  init_in = 1'b1; tick(); init_in = 1'b0; endtask
    task automatic pulse_inh(input logic [2:0] b);
        inh_bits = b; inh_req = 1'b1; tick(); inh_req = 1'b0; inh_bits = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: queued=%0d expected 0", q.size());
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        vectors++;
        if (take !== T_NONE || take_vec !== 8'h00 || loc_ack || leg_ack) begin
            fails++;
            $display("FAIL R1 reset: take=%b vec=%h expected 0000000 00", take, take_vec);
        end
        check_pend(1'b0, "R12 reset");

        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R1 empty boundary");

        // R7 / R11: interrupt beats hold, hold alone granted
        if_flag = 1'b1; leg_irq = 1'b1; leg_vec = 8'h20; hold_req = 1'b1;
        boundary(16'h0, T_INTR, 8'h20, 0, 1, "R11 intr over hold");
        leg_irq = 1'b0;
        boundary(16'h0, T_HOLD, 8'h00, 0, 0, "R11 hold granted");
        hold_req = 1'b0;

        // R7: local controller first
        loc_irq = 1'b1; loc_vec = 8'h41; leg_irq = 1'b1;
        boundary(16'h0, T_INTR, 8'h41, 1, 0, "R7 local first");
        loc_irq = 1'b0;
        boundary(16'h0, T_INTR, 8'h20, 0, 1, "R7 legacy ack");
        if_flag = 1'b0;
        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R7 IF clear");
        check_pend(1'b0, "R12 masked irq only");

        // R6: NMI over interrupt, self-mask, unmask
        if_flag = 1'b1;
        pulse_nmi();
        boundary(16'h0, T_NMI, 8'h02, 0, 0, "R6 nmi vector 2");
        pulse_nmi();
        boundary(16'h0, T_INTR, 8'h20, 0, 1, "R6 blocked nmi lets intr");
        leg_irq = 1'b0;
        pulse_unmask();
        boundary(16'h0, T_NMI, 8'h02, 0, 0, "R6 after unmask");
        pulse_unmask();

        // R2 / R4 / R5: SMI, INIT, NMI order
        pulse_smi(); pulse_init(); pulse_nmi();
        boundary(16'h0, T_SMI, 8'h00, 0, 0, "R2 smi first");
        boundary(16'h0, T_INIT, 8'h00, 0, 0, "R5 init next");
        boundary(16'h0, T_NMI, 8'h02, 0, 0, "R2 nmi last");
        pulse_unmask();

        // R4: masked SMI stays pending
        smi_mask = 1'b1; hold_req = 1'b1;
        pulse_smi();
        boundary(16'h0, T_HOLD, 8'h00, 0, 0, "R4 smi held off");
        hold_req = 1'b0; smi_mask = 1'b0;
        boundary(16'h0, T_SMI, 8'h00, 0, 0, "R4 smi after mask");

        // R5: INIT arriving masked is dropped
        init_mask = 1'b1;
        pulse_init();
        init_mask = 1'b0;
        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R5 masked init dropped");

        // R3: task-switch trap over SMI
        pulse_smi();
        ts_trap = 1'b1;
        boundary(16'h0, T_TS, 8'h01, 0, 0, "R3 task switch trap");
        ts_trap = 1'b0;
        boundary(16'h0, T_SMI, 8'h00, 0, 0, "R2 smi after ts");

        // R8: debug trap bits
        boundary(16'h2000, T_DBG, 8'h01, 0, 0, "R8 bit13 fires");
        boundary(16'h0008, T_NONE, 8'h00, 0, 0, "R8 low bit no fire");
        check_pend(1'b0, "R8 word cleared");
        tf_flag = 1'b1;
        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R8 tf schedules");
        tf_flag = 1'b0;
        check_pend(1'b1, "R12 step pending");
        boundary(16'h0, T_DBG, 8'h01, 0, 0, "R8 single step");

        // R9: interrupt shadow covers one boundary
        pulse_inh(3'b001);
        pulse_nmi();
        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R9 nmi shadowed");
        boundary(16'h0, T_NMI, 8'h02, 0, 0, "R9 nmi after shadow");
        pulse_unmask();
        pulse_inh(3'b001);
        boundary(16'h4000, T_DBG, 8'h01, 0, 0, "R9 debug not in intr shadow");

        // R10: stack-load shadow ignores a second request
        pulse_inh(3'b111);
        pulse_nmi();
        boundary(16'h1000, T_NONE, 8'h00, 0, 0, "R9 full shadow");
        pulse_inh(3'b111);
        boundary(16'h0, T_DBG, 8'h01, 0, 0, "R10 second request ignored");
        boundary(16'h0, T_NMI, 8'h02, 0, 0, "R2 nmi after dbg");
        pulse_unmask();

        // R10: plain shadow re-arms
        pulse_inh(3'b001);
        pulse_nmi();
        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R9 first shadow");
        pulse_inh(3'b001);
        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R10 rearmed shadow");
        boundary(16'h0, T_NMI, 8'h02, 0, 0, "R10 nmi after rearm");
        pulse_unmask();

        boundary(16'h0, T_NONE, 8'h00, 0, 0, "R12 quiet boundary");
        check_pend(1'b0, "R12 summary clear");

        tick(); tick();
        vectors++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 leftover expectations: %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule